// File: doc/BRIEF.md
# Serial Operand Stack and Memory Register Controller

This block holds a four-level operand stack and one memory register as five 56-bit words, each kept in a serial shift register that recirculates one bit per clock. A word is fourteen 4-bit digits, least significant bit first. The bottom stack level is C, which is the displayed value. D and E are the middle levels and F is the top. The memory register M can only trade data with C.

Commands arrive as 10-bit instruction words. The block can push or pop the stack, rotate it downward, swap or recall the memory register, clear all five words, or insert one constant digit into C at the digit chosen by a 4-bit pointer. The pointer then steps down by one. Every data move is a serial transfer that fills exactly one 56-bit word period, and that period starts on a word boundary. Two instructions only change a display-enable flag. A separate input loads the pointer.

Top module: `stack_ser_ctl`

## Requirements
- R1: While reset is low, and in the first cycle after it, all five words read zero, `ptr` is 0, `disp_on` is 0 and `word_sync` is 1.
- R2: Each `*_out` pin presents bit k of its word in the cycle where the bit counter equals k. `word_sync` is high only at bit 0, once every 56 cycles. When no transfer runs, every word repeats unchanged.
- R3: A transfer instruction is accepted on a clock with `instr_valid` high only when nothing is pending or running. It runs during the next word period that starts at bit 0. The outputs show the old words for that whole period and the new words from the following bit 0 onward. Instructions that arrive while a transfer is pending or running have no effect.
- R4: Push, encoded 0100101000, leaves C unchanged and gives D = old C, E = old D, F = old E. M is unchanged.
- R5: Pop, encoded 0110101000, gives C = old D, D = old E, E = old F. F and M are unchanged.
- R6: Rotate down, encoded 1100101000, gives C = old D, D = old E, E = old F and F = old C.
- R7: Swap, encoded 0010101000, exchanges C and M. Recall, encoded 1010101000, copies M into C and leaves M unchanged.
- R8: Clear, encoded 1110101000, sets all five words to zero and leaves `ptr` unchanged.
- R9: Constant load, any word whose bits [5:0] are 011000, writes instr[9:6] into the digit of C at bits 4P+3..4P, where P is `ptr`. All other digits and all other words are unchanged.
- R10: At the end of a constant load, `ptr` decrements by one, and a value of 0 wraps to 13.
- R11: When the block is idle, `ptr_load` writes `ptr_value` into `ptr` on the next clock. While a transfer is pending or running, `ptr_load` is ignored.
- R12: Display off, encoded 1000101000, clears `disp_on` on the next clock. Display toggle, encoded 0000101000, inverts it on the next clock. Both work even while a transfer is busy.
- R13: Any other encoding changes no word, no pointer and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 10 | Instruction word |
| instr_valid | input | 1 | Marks `instr` as present this cycle |
| ptr_load | input | 1 | Load request for the digit pointer |
| ptr_value | input | 4 | Value for the pointer |
| c_out | output | 1 | Serial bit of C (stack bottom) |
| d_out | output | 1 | Serial bit of D |
| e_out | output | 1 | Serial bit of E |
| f_out | output | 1 | Serial bit of F (stack top) |
| m_out | output | 1 | Serial bit of M |
| word_sync | output | 1 | High during bit 0 of each word |
| ptr | output | 4 | Digit pointer |
| disp_on | output | 1 | Display enable flag |

## Verification
The words are first filled by fourteen constant loads that walk the pointer from 13 down through the wrap. This gives every digit of C a distinct value, so any misplaced digit or bit shows up in the result. Push, rotate, swap, recall and pop then run on stacks whose levels all differ, so a wrong source or a missing move is visible in at least one word. A copy of the stacks is also taken during each running transfer, which shows that the new contents appear exactly one word period later. Instructions and pointer loads sent while the block is busy, along with undefined encodings, are followed by reads of every word and of the pointer to confirm that nothing changed.

// File: rtl/ssc_pkg.sv
// Shared types and instruction encodings for the serial stack controller.
// Assumes a 10-bit instruction whose low six bits select the command class.
package ssc_pkg;

    localparam int INSTR_W    = 10;
    localparam int DIGIT_BITS = 4;

    // Low-field patterns that mark the two command classes.
    localparam logic [5:0] CLASS_MOVE  = 6'b101000;
    localparam logic [5:0] CLASS_KLOAD = 6'b011000;

    // Selector values held in instr[9:6] for the move class.
    localparam logic [3:0] SEL_TOGGLE = 4'b0000;
    localparam logic [3:0] SEL_SWAP   = 4'b0010;
    localparam logic [3:0] SEL_PUSH   = 4'b0100;
    localparam logic [3:0] SEL_POP    = 4'b0110;
    localparam logic [3:0] SEL_OFF    = 4'b1000;
    localparam logic [3:0] SEL_RECALL = 4'b1010;
    localparam logic [3:0] SEL_ROLL   = 4'b1100;
    localparam logic [3:0] SEL_CLEAR  = 4'b1110;

    typedef enum logic [3:0] {
        OP_NONE, OP_PUSH, OP_POP, OP_ROLL, OP_SWAP_M,
        OP_RECALL, OP_CLEAR, OP_KLOAD, OP_DISP_TOG, OP_DISP_OFF
    } op_e;

    typedef struct packed {
        op_e                   op;
        logic [DIGIT_BITS-1:0] konst;
    } cmd_t;

    // True for commands that need a full serial word period.
    function automatic logic is_transfer(op_e o);
        case (o)
            OP_PUSH, OP_POP, OP_ROLL, OP_SWAP_M,
            OP_RECALL, OP_CLEAR, OP_KLOAD: return 1'b1;
            default:                       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ssc_decode.sv
// Instruction decoder: maps a 10-bit instruction word to a command.
// Purely combinational. Unknown words decode to OP_NONE.
module ssc_decode
    import ssc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output cmd_t               cmd
);

    // Classify by the low field, then by the selector in bits [9:6].
    always_comb begin
        cmd.op    = OP_NONE;
        cmd.konst = instr[INSTR_W-1 -: DIGIT_BITS];
        if (instr[5:0] == CLASS_KLOAD) begin
            cmd.op = OP_KLOAD;
        end else if (instr[5:0] == CLASS_MOVE) begin
            case (instr[9:6])
                SEL_TOGGLE: cmd.op = OP_DISP_TOG;
                SEL_SWAP:   cmd.op = OP_SWAP_M;
                SEL_PUSH:   cmd.op = OP_PUSH;
                SEL_POP:    cmd.op = OP_POP;
                SEL_OFF:    cmd.op = OP_DISP_OFF;
                SEL_RECALL: cmd.op = OP_RECALL;
                SEL_ROLL:   cmd.op = OP_ROLL;
                SEL_CLEAR:  cmd.op = OP_CLEAR;
                default:    cmd.op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ssc_sequencer.sv
// Word-period sequencer: runs the bit counter, holds an accepted transfer
// until the next bit 0, runs it for one full word, then steps the pointer.
// It also owns the display flag. Assumes the decoder output is stable
// whenever instr_valid is high.
module ssc_sequencer
    import ssc_pkg::*;
#(
    parameter  int NUM_DIGITS = 14,
    localparam int WORD       = NUM_DIGITS * DIGIT_BITS,
    localparam int CNT_W      = $clog2(WORD),
    localparam int PTR_W      = $clog2(NUM_DIGITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  cmd_t             cmd,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_value,
    output logic             xfer,
    output cmd_t             act,
    output logic [CNT_W-1:0] bit_pos,
    output logic [PTR_W-1:0] ptr,
    output logic             disp_on,
    output logic             word_sync
);

    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(WORD - 1);
    localparam logic [PTR_W-1:0] LAST_DIGIT = PTR_W'(NUM_DIGITS - 1);
    localparam logic [PTR_W-1:0] PTR_ONE    = PTR_W'(1);

    logic pend;
    logic run;
    logic idle;
    logic word_end;

    assign idle      = !pend && !run;
    assign word_end  = (bit_pos == LAST_BIT);
    assign word_sync = (bit_pos == '0);
    assign xfer      = run || (pend && word_sync);

    // Free-running bit counter over one serial word.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_pos <= '0;
        else if (word_end) bit_pos <= '0;
        else               bit_pos <= bit_pos + CNT_W'(1);
    end

    // Pending/running state of the one transfer in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            run  <= 1'b0;
            act  <= '{op: OP_NONE, konst: '0};
        end else begin
            if (pend && word_sync) begin
                pend <= 1'b0;
                run  <= 1'b1;
            end
            if (run && word_end) run <= 1'b0;
            if (instr_valid && idle && is_transfer(cmd.op)) begin
                pend <= 1'b1;
                act  <= cmd;
            end
        end
    end

    // Digit pointer: idle load, or step down at the end of a constant load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (run && word_end && act.op == OP_KLOAD) begin
            ptr <= (ptr == '0) ? LAST_DIGIT : ptr - PTR_ONE;
        end else if (ptr_load && idle) begin
            ptr <= ptr_value;
        end
    end

    // Display flag, which takes effect right away even while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_on <= 1'b0;
        end else if (instr_valid && cmd.op == OP_DISP_OFF) begin
            disp_on <= 1'b0;
        end else if (instr_valid && cmd.op == OP_DISP_TOG) begin
            disp_on <= !disp_on;
        end
    end

    AST_PEND_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend && run)); // R3
    AST_RUN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> bit_pos == CNT_W'(1)); // R3
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && word_end && act.op == OP_KLOAD && ptr == '0) |=> ptr == LAST_DIGIT); // R10
    AST_PTR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend || (run && !word_end)) |=> $stable(ptr)); // R11
    AST_DISP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cmd.op == OP_DISP_TOG) |=> disp_on != $past(disp_on)); // R12
    AST_DISP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cmd.op == OP_DISP_OFF) |=> !disp_on); // R12

endmodule

// File: rtl/ssc_shreg.sv
// One recirculating serial word: shifts right one bit per clock.
// The bit at position 0 is the output. The new bit enters at the top.
module ssc_shreg #(
    parameter int WIDTH = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    output logic out_bit
);

    logic [WIDTH-1:0] q;

    // Shift the incoming bit in at the most significant end.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= {in_bit, q[WIDTH-1:1]};
    end

    assign out_bit = q[0];

endmodule

// File: rtl/stack_ser_ctl.sv
// Serial stack controller top level: five recirculating words (C, D, E, F, M),
// the decoder, the sequencer and the per-word input routing. Assumes inputs
// are synchronous to clk and that one word period equals NUM_DIGITS digits.
module stack_ser_ctl
    import ssc_pkg::*;
#(
    parameter  int NUM_DIGITS = 14,
    localparam int PTR_W      = $clog2(NUM_DIGITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               instr_valid,
    input  logic               ptr_load,
    input  logic [PTR_W-1:0]   ptr_value,
    output logic               c_out,
    output logic               d_out,
    output logic               e_out,
    output logic               f_out,
    output logic               m_out,
    output logic               word_sync,
    output logic [PTR_W-1:0]   ptr,
    output logic               disp_on
);

    localparam int WORD    = NUM_DIGITS * DIGIT_BITS;
    localparam int CNT_W   = $clog2(WORD);
    localparam int DIG_LOG = $clog2(DIGIT_BITS);
    localparam int NREG    = 5;
    localparam int IX_C    = 0;
    localparam int IX_D    = 1;
    localparam int IX_E    = 2;
    localparam int IX_F    = 3;
    localparam int IX_M    = 4;

    cmd_t             cmd;
    cmd_t             act;
    logic             xfer;
    logic [CNT_W-1:0] bit_pos;
    logic [NREG-1:0]  lane_in;
    logic [NREG-1:0]  lane_out;
    logic             in_digit;
    logic             k_bit;

    ssc_decode u_decode (
        .instr (instr),
        .cmd   (cmd)
    );

    ssc_sequencer #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .cmd         (cmd),
        .ptr_load    (ptr_load),
        .ptr_value   (ptr_value),
        .xfer        (xfer),
        .act         (act),
        .bit_pos     (bit_pos),
        .ptr         (ptr),
        .disp_on     (disp_on),
        .word_sync   (word_sync)
    );

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_word
            ssc_shreg #(.WIDTH(WORD)) u_word (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_bit  (lane_in[g]),
                .out_bit (lane_out[g])
            );
        end
    endgenerate

    assign in_digit = (PTR_W'(bit_pos >> DIG_LOG) == ptr);
    assign k_bit    = act.konst[bit_pos[DIG_LOG-1:0]];

    // Route each word's input: recirculate by default, else the transfer source.
    always_comb begin
        lane_in = lane_out;
        if (xfer) begin
            case (act.op)
                OP_PUSH: begin
                    lane_in[IX_D] = lane_out[IX_C];
                    lane_in[IX_E] = lane_out[IX_D];
                    lane_in[IX_F] = lane_out[IX_E];
                end
                OP_POP: begin
                    lane_in[IX_C] = lane_out[IX_D];
                    lane_in[IX_D] = lane_out[IX_E];
                    lane_in[IX_E] = lane_out[IX_F];
                end
                OP_ROLL: begin
                    lane_in[IX_C] = lane_out[IX_D];
                    lane_in[IX_D] = lane_out[IX_E];
                    lane_in[IX_E] = lane_out[IX_F];
                    lane_in[IX_F] = lane_out[IX_C];
                end
                OP_SWAP_M: begin
                    lane_in[IX_C] = lane_out[IX_M];
                    lane_in[IX_M] = lane_out[IX_C];
                end
                OP_RECALL: lane_in[IX_C] = lane_out[IX_M];
                OP_CLEAR:  lane_in = '0;
                OP_KLOAD:  if (in_digit) lane_in[IX_C] = k_bit;
                default:   lane_in = lane_out;
            endcase
        end
    end

    assign c_out = lane_out[IX_C];
    assign d_out = lane_out[IX_D];
    assign e_out = lane_out[IX_E];
    assign f_out = lane_out[IX_F];
    assign m_out = lane_out[IX_M];

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_sync |=> !word_sync); // R2
    AST_IDLE_RECIRC: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |-> $countones(lane_in ^ lane_out) == 0); // R2

endmodule

// File: tb/stack_ser_ctl_bench.sv
`timescale 1ns/1ps
// Bench: a behavioural whole-word model that is compared on every clock,
// plus scenario checks made on words read back from the serial outputs.
module stack_ser_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] instr = '0;
    logic       instr_valid = 1'b0;
    logic       ptr_load = 1'b0;
    logic [3:0] ptr_value = '0;
    logic       c_out, d_out, e_out, f_out, m_out, word_sync, disp_on;
    logic [3:0] ptr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    stack_ser_ctl u_stack_ser_ctl (
        .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid),
        .ptr_load(ptr_load), .ptr_value(ptr_value),
        .c_out(c_out), .d_out(d_out), .e_out(e_out), .f_out(f_out), .m_out(m_out),
        .word_sync(word_sync), .ptr(ptr), .disp_on(disp_on)
    );

    // Reference model state: whole words, a bit index and the busy flags.
    logic [55:0] mw [5];
    int  mt, mop, mptr;
    logic [3:0] mk;
    bit  mpend, mrun, mdisp;

    // Codes: 1 push 2 pop 3 roll 4 swap 5 recall 6 clear 7 kload 8 toggle 9 off.
    function automatic int mdecode(logic [9:0] w);
        if (w[5:0] == 6'b011000) return 7;
        if (w[5:0] != 6'b101000) return 0;
        case (w[9:6])
            4'd4: return 1;   4'd6: return 2;   4'd12: return 3;
            4'd2: return 4;   4'd10: return 5;  4'd14: return 6;
            4'd0: return 8;   4'd8: return 9;
            default: return 0;
        endcase
    endfunction

    // Advance the model by one clock.
    always @(posedge clk) begin
        bit p0, r0;
        int t0, code;
        logic [55:0] o [5];
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) mw[i] = '0;
            mt = 0; mop = 0; mk = '0; mptr = 0; mpend = 0; mrun = 0; mdisp = 0;
        end else begin
            p0 = mpend; r0 = mrun; t0 = mt;
            code = instr_valid ? mdecode(instr) : 0;
            mt = (t0 + 1) % 56;
            if (r0 && t0 == 55) begin
                for (int i = 0; i < 5; i++) o[i] = mw[i];
                case (mop)
                    1: begin mw[1] = o[0]; mw[2] = o[1]; mw[3] = o[2]; end
                    2: begin mw[0] = o[1]; mw[1] = o[2]; mw[2] = o[3]; end
                    3: begin mw[0] = o[1]; mw[1] = o[2]; mw[2] = o[3]; mw[3] = o[0]; end
                    4: begin mw[0] = o[4]; mw[4] = o[0]; end
                    5: mw[0] = o[4];
                    6: for (int i = 0; i < 5; i++) mw[i] = '0;
                    7: begin
                        mw[0][4*mptr +: 4] = mk;
                        mptr = (mptr == 0) ? 13 : mptr - 1;
                    end
                    default: ;
                endcase
                mrun = 0;
            end
            if (p0 && t0 == 0) begin mpend = 0; mrun = 1; end
            if (code >= 1 && code <= 7 && !p0 && !r0) begin
                mpend = 1; mop = code; mk = instr[9:6];
            end
            if (ptr_load && !p0 && !r0) mptr = int'(ptr_value);
            if (code == 8) mdisp = !mdisp;
            if (code == 9) mdisp = 0;
        end
    end

    // Compare the design with the model in the middle of every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ({c_out, d_out, e_out, f_out, m_out} !==
                {mw[0][mt], mw[1][mt], mw[2][mt], mw[3][mt], mw[4][mt]}) begin
                errors++;
                $display("FAIL R2 serial bits at t=%0d act=%b exp=%b", mt,
                    {c_out, d_out, e_out, f_out, m_out},
                    {mw[0][mt], mw[1][mt], mw[2][mt], mw[3][mt], mw[4][mt]});
            end
            if (word_sync !== (mt == 0)) begin
                errors++;
                $display("FAIL R2 word_sync act=%b exp=%b", word_sync, (mt == 0));
            end
            if (int'(ptr) != mptr) begin
                errors++;
                $display("FAIL R10 ptr act=%0d exp=%0d", ptr, mptr);
            end
            if (disp_on !== mdisp) begin
                errors++;
                $display("FAIL R12 disp_on act=%b exp=%b", disp_on, mdisp);
            end
        end
    end

    task automatic chk(input string tag, input logic [55:0] act, input logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [9:0] w);
        @(negedge clk);
        instr = w; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0; instr = '0;
    endtask

    task automatic settle();
        repeat (115) @(negedge clk);
    endtask

    // Read one whole word of each register from the serial pins.
    task automatic grab(output logic [55:0] c, d, e, f, m);
        while (!word_sync) @(negedge clk);
        for (int i = 0; i < 56; i++) begin
            c[i] = c_out; d[i] = d_out; e[i] = e_out; f[i] = f_out; m[i] = m_out;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [55:0] c0, d0, e0, f0, m0, c1, d1, e1, f1, m1, kexp;
        int p_before;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ptr", 56'(ptr), 56'd0);
        chk("R1 disp_on", 56'(disp_on), 56'd0);
        chk("R1 word_sync", 56'(word_sync), 56'd1);
        rst_n = 1'b1;
        grab(c0, d0, e0, f0, m0);
        chk("R1 words zero", c0 | d0 | e0 | f0 | m0, 56'd0);

        // R11: idle pointer load
        @(negedge clk); ptr_load = 1'b1; ptr_value = 4'd13;
        @(negedge clk); ptr_load = 1'b0;
        chk("R11 ptr load idle", 56'(ptr), 56'd13);

        // R9 and R10: fourteen constant loads walk the pointer down and wrap
        for (int i = 0; i < 14; i++) begin
            issue({4'(i + 1), 6'b011000});
            settle();
        end
        kexp = '0;
        for (int d = 0; d < 14; d++) kexp[4*d +: 4] = 4'(14 - d);
        grab(c0, d0, e0, f0, m0);
        chk("R9 constant digits in C", c0, kexp);
        chk("R9 D untouched", d0, 56'd0);
        chk("R10 ptr wrapped to 13", 56'(ptr), 56'd13);

        // R4: push
        issue(10'b0100101000); settle();
        grab(c1, d1, e1, f1, m1);
        chk("R4 push C", c1, c0);
        chk("R4 push D", d1, c0);
        chk("R4 push E", e1, d0);
        chk("R4 push F", f1, e0);
        chk("R4 push M", m1, m0);

        // Make C differ from D: write digit 0 and wrap the pointer again (R10)
        @(negedge clk); ptr_load = 1'b1; ptr_value = 4'd0;
        @(negedge clk); ptr_load = 1'b0;
        issue(10'b0111011000); settle();
        chk("R10 wrap from 0", 56'(ptr), 56'd13);
        issue(10'b0100101000); settle();
        @(negedge clk); ptr_load = 1'b1; ptr_value = 4'd5;
        @(negedge clk); ptr_load = 1'b0;
        issue(10'b0011011000); settle();
        grab(c0, d0, e0, f0, m0);
        chk("R9 digit 5 write", 56'(c0[23:20]), 56'd3);
        chk("R9 other digits kept", c0 & ~(56'hF << 20), d0 & ~(56'hF << 20));

        // R3 and R6: rotate; the running word still shows old contents
        issue(10'b1100101000);
        grab(c1, d1, e1, f1, m1);
        chk("R3 old C during run", c1, c0);
        chk("R3 old F during run", f1, f0);
        grab(c1, d1, e1, f1, m1);
        chk("R6 rotate C", c1, d0);
        chk("R6 rotate D", d1, e0);
        chk("R6 rotate E", e1, f0);
        chk("R6 rotate F", f1, c0);

        // R7: swap with M, then recall
        c0 = c1; d0 = d1; e0 = e1; f0 = f1; m0 = m1;
        issue(10'b0010101000); settle();
        grab(c1, d1, e1, f1, m1);
        chk("R7 swap C", c1, m0);
        chk("R7 swap M", m1, c0);
        issue(10'b1010101000); settle();
        grab(c0, d0, e0, f0, m0);
        chk("R7 recall C", c0, m1);
        chk("R7 recall M kept", m0, m1);

        // R5: pop
        issue(10'b0110101000); settle();
        grab(c1, d1, e1, f1, m1);
        chk("R5 pop C", c1, d0);
        chk("R5 pop D", d1, e0);
        chk("R5 pop E", e1, f0);
        chk("R5 pop F kept", f1, f0);

        // R13: undefined encodings do nothing
        p_before = int'(ptr);
        issue(10'b0001101000);
        issue(10'b1111011001);
        issue(10'b0000000000);
        settle();
        grab(c0, d0, e0, f0, m0);
        chk("R13 C kept", c0, c1);
        chk("R13 F kept", f0, f1);
        chk("R13 M kept", m0, m1);
        chk("R13 ptr kept", 56'(ptr), 56'(p_before));

        // R3 and R11: second instruction and pointer load while busy are ignored
        issue(10'b0100101000);
        @(negedge clk); instr = 10'b1110101000; instr_valid = 1'b1;
        ptr_load = 1'b1; ptr_value = 4'd2;
        @(negedge clk); instr_valid = 1'b0; instr = '0; ptr_load = 1'b0;
        chk("R11 ptr load ignored when busy", 56'(ptr), 56'(p_before));
        settle();
        grab(c1, d1, e1, f1, m1);
        chk("R3 busy clear ignored, C", c1, c0);
        chk("R3 busy clear ignored, D", d1, c0);
        chk("R3 busy clear ignored, F", f1, e0);

        // R12: display flag control
        issue(10'b0000101000);
        chk("R12 toggle on", 56'(disp_on), 56'd1);
        issue(10'b0000101000);
        chk("R12 toggle off", 56'(disp_on), 56'd0);
        issue(10'b0000101000);
        issue(10'b1000101000);
        chk("R12 display off", 56'(disp_on), 56'd0);
        issue(10'b1000101000);
        chk("R12 off stays off", 56'(disp_on), 56'd0);

        // R8: clear
        issue(10'b1110101000); settle();
        grab(c0, d0, e0, f0, m0);
        chk("R8 clear all", c0 | d0 | e0 | f0 | m0, 56'd0);
        chk("R8 ptr kept", 56'(ptr), 56'(p_before));

        summary();
    end

endmodule